// File: doc/BRIEF.md
# Streaming Systematic Syndrome Encoder

This block produces the ciphertext of a code-based public-key scheme in systematic form. The ciphertext has R = M·T bits and is the GF(2) product of the matrix [I | K] with an N-bit plaintext (error) vector e. The identity part of the matrix is never stored and never multiplied. Instead, loading a plaintext copies its low R bits straight into an R-bit accumulator.

The remaining N−R columns of the public key K then arrive one per clock, each qualified by a valid strobe. The block XORs each accepted column into the accumulator when the plaintext bit paired with that column is set. After the last column has been accepted, the block raises a completion flag and holds its result. It ignores further columns until the next load. The block stores no key material, and the column source decides the pace of the column stream.

Top module: `syndrome_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cipher_out` becomes all zeros and `done` becomes 0 after that edge.
- R2: A clock edge with `start` high captures `plain_in`. After that edge, `cipher_out[i]` equals `plain_in[i]` for every i below R, and `done` is 0.
- R3: While a run is active, a column is accepted at an edge where `col_valid` is high and `start` is low. Let k be the number of columns accepted since the load. The accepted column is XORed into `cipher_out` when `plain_in[R+k]` of the captured plaintext is 1, and leaves `cipher_out` unchanged when that bit is 0.
- R4: An edge with `col_valid` low and `start` low changes neither `cipher_out` nor `done`.
- R5: `done` rises at the edge that accepts the (N−R)-th column of a run, and at no earlier edge. From then on, `cipher_out` equals [I | K]·e over GF(2).
- R6: Once `done` is high, columns offered with `col_valid` high change neither `cipher_out` nor `done`, until the next `start`.
- R7: `start` asserted during an unfinished run abandons that run and reloads as in R2. A column offered at the same edge as `start` is ignored.
- R8: After reset and before any `start`, offered columns are ignored, and `cipher_out` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load plaintext and begin a new run |
| plain_in | input | N | Plaintext vector e, sampled when `start` is high |
| col_in | input | R | One public-key column, bit i = row i |
| col_valid | input | 1 | Qualifies `col_in` for the current edge |
| cipher_out | output | R | Accumulated ciphertext |
| done | output | 1 | All N−R columns of the run have been accepted |

## Verification
The bench sweeps every combination of the column-select plaintext bits. A design that pairs a column with the wrong plaintext bit, for example one that is off by one or reversed, therefore gives a wrong ciphertext for most patterns. Every column is checked with `done` as well, so a design that raises the flag one column early or late is caught at that column. Idle gaps are placed between columns, so a design that accumulates on an invalid cycle corrupts the result. Columns are also pushed after completion and before any load, to catch a design that keeps accumulating when it should not. A restart in mid-run, with a column offered in the load cycle, catches a design that keeps the stale count or takes that column.

// File: rtl/syndenc_pkg.sv
// Shared types for the syndrome encoder.
package syndenc_pkg;

    // Run phases: waiting for a load, taking columns, result held.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HELD = 2'd2
    } run_phase_t;

endpackage

// File: rtl/syn_seq_ctrl.sv
// Run sequencer.
// Tracks the run phase and counts accepted columns.
// A column is accepted only while a run is active and no load is requested.
// The phase moves to held on the acceptance of the last column.
// Assumes NCOLS >= 1.
module syn_seq_ctrl
    import syndenc_pkg::*;
#(
    parameter int NCOLS = 8,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          col_valid,
    output logic          accept,
    output logic [CW-1:0] col_idx,
    output logic          held
);

    localparam logic [CW-1:0] LAST_IDX = CW'(NCOLS - 1);

    run_phase_t    phase_q;
    logic [CW-1:0] idx_q;
    logic          is_last;

    // Acceptance qualifier and last-column detect.
    always_comb begin
        accept  = (phase_q == PH_RUN) && col_valid && !start;
        is_last = (idx_q == LAST_IDX);
    end

    // Phase and column-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (start) begin
            phase_q <= PH_RUN;
            idx_q   <= '0;
        end else if (accept) begin
            if (is_last) begin
                phase_q <= PH_HELD;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign col_idx = idx_q;
    assign held    = (phase_q == PH_HELD);

endmodule

// File: rtl/syn_bit_pick.sv
// Plaintext select store.
// Captures the upper N-R plaintext bits at load time.
// Presents the bit paired with the current column index.
// Assumes col_idx stays below NCOLS.
module syn_bit_pick #(
    parameter int NCOLS = 8,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCOLS-1:0] sel_in,
    input  logic [CW-1:0]    col_idx,
    output logic             pick
);

    logic [NCOLS-1:0] sel_q;

    // Hold the select bits for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= sel_in;
        end
    end

    // Select the bit that governs the current column.
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NCOLS; i++) begin
            if (col_idx == CW'(i)) pick = sel_q[i];
        end
    end

endmodule

// File: rtl/syn_acc.sv
// GF(2) accumulator.
// Each row bit is its own flop.
// A load writes the identity contribution; an accumulate XORs a column in.
// Load has priority over accumulate.
module syn_acc #(
    parameter int ROWS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ROWS-1:0] load_val,
    input  logic            acc_en,
    input  logic [ROWS-1:0] col,
    output logic [ROWS-1:0] acc
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic bit_q;

        // One row of the syndrome: copy on load, XOR on accumulate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (load) begin
                bit_q <= load_val[r];
            end else if (acc_en) begin
                bit_q <= bit_q ^ col[r];
            end
        end

        assign acc[r] = bit_q;
    end

endmodule

// File: rtl/syndrome_encoder.sv
// Streaming systematic syndrome encoder.
// Computes cipher = [I | K] * e over GF(2).
// The identity part is a copy of e[R-1:0] at load time.
// The K columns stream in and are XORed in when their paired plaintext bit is set.
// Assumes N > M*T.
module syndrome_encoder #(
    parameter int M = 4,
    parameter int T = 2,
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N-1:0]      plain_in,
    input  logic [M*T-1:0]    col_in,
    input  logic              col_valid,
    output logic [M*T-1:0]    cipher_out,
    output logic              done
);

    localparam int R  = M * T;
    localparam int KC = N - R;
    localparam int CW = (KC > 1) ? $clog2(KC) : 1;

    logic          accept;
    logic [CW-1:0] col_idx;
    logic          pick_bit;
    logic          acc_en;

    syn_seq_ctrl #(.NCOLS(KC), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .col_valid (col_valid),
        .accept    (accept),
        .col_idx   (col_idx),
        .held      (done)
    );

    syn_bit_pick #(.NCOLS(KC), .CW(CW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .sel_in  (plain_in[N-1:R]),
        .col_idx (col_idx),
        .pick    (pick_bit)
    );

    // Accumulate only accepted columns whose plaintext bit is set.
    assign acc_en = accept && pick_bit;

    syn_acc #(.ROWS(R)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (plain_in[R-1:0]),
        .acc_en   (acc_en),
        .col      (col_in),
        .acc      (cipher_out)
    );

endmodule

// File: rtl/syndrome_encoder_chk.sv
// Assertion checker for syndrome_encoder, attached by bind.
module syndrome_encoder_chk #(
    parameter int R = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [R-1:0] plain_lo,
    input logic [R-1:0] col_in,
    input logic         col_valid,
    input logic [R-1:0] cipher_out,
    input logic         done,
    input logic         accept,
    input logic         pick_bit
);

    // R1: reset clears the result and the flag.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cipher_out == '0 && !done));

    // R2, R7: a load copies the identity part and clears done.
    a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cipher_out == $past(plain_lo) && !done));

    // R3: a column with a clear select bit leaves the result alone.
    a_r3_skip_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pick_bit) |=> $stable(cipher_out));

    // R3: a column with a set select bit is XORed in.
    a_r3_xor_set: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pick_bit) |=> (cipher_out == ($past(cipher_out) ^ $past(col_in))));

    // R4: an idle cycle changes nothing.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !col_valid) |=> ($stable(cipher_out) && $stable(done)));

    // R5: done only rises on an accepted column.
    a_r5_done_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept));

    // R6: the held result survives offered columns.
    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cipher_out)));

    // R8: columns that are not accepted never touch the result.
    a_r8_unaccepted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !accept) |=> $stable(cipher_out));

endmodule

bind syndrome_encoder syndrome_encoder_chk #(.R(R)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .plain_lo   (plain_in[R-1:0]),
    .col_in     (col_in),
    .col_valid  (col_valid),
    .cipher_out (cipher_out),
    .done       (done),
    .accept     (accept),
    .pick_bit   (pick_bit)
);

// File: tb/tb_syndrome_encoder.sv
module tb_syndrome_encoder;

    localparam int M  = 4;
    localparam int T  = 2;
    localparam int N  = 16;
    localparam int R  = M * T;
    localparam int KC = N - R;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  plain_in = '0;
    logic [R-1:0]  col_in = '0;
    logic          col_valid = 1'b0;
    logic [R-1:0]  cipher_out;
    logic          done;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    syndrome_encoder #(.M(M), .T(T), .N(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plain_in   (plain_in),
        .col_in     (col_in),
        .col_valid  (col_valid),
        .cipher_out (cipher_out),
        .done       (done)
    );

    // Pseudo key column generator.
    function automatic logic [R-1:0] key_col(input int seed, input int k);
        int v;
        v = seed * 97 + k * 53 + 11;
        return R'(v ^ (v >> 3) ^ (k << 2));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full run. ltag names the load check (R2 or R7).
    task automatic run_vec(input logic [N-1:0] pv, input int seed, input bit gaps, input string ltag);
        logic [R-1:0] exp;
        // Load cycle with a junk column that must be ignored (R7).
        start = 1'b1; plain_in = pv; col_valid = 1'b1; col_in = key_col(seed, 99);
        @(negedge clk);
        start = 1'b0; col_valid = 1'b0;
        exp = pv[R-1:0];
        chk(cipher_out == exp && !done, ltag, {23'd0, done, cipher_out}, {24'd0, exp});
        for (int k = 0; k < KC; k++) begin
            if (gaps && (k % 2 == 1)) begin
                col_valid = 1'b0; col_in = ~key_col(seed, k);
                @(negedge clk);
                chk(cipher_out == exp && !done, "R4", {23'd0, done, cipher_out}, {24'd0, exp});
            end
            col_valid = 1'b1; col_in = key_col(seed, k);
            @(negedge clk);
            if (pv[R+k]) exp = exp ^ key_col(seed, k);
            chk(cipher_out == exp, "R3", 32'(cipher_out), 32'(exp));
            chk(done == (k == KC - 1), "R5", 32'(done), 32'(k == KC - 1));
        end
        // Column after completion must be ignored (R6).
        col_valid = 1'b1; col_in = key_col(seed, 200);
        @(negedge clk);
        col_valid = 1'b0;
        chk(done && cipher_out == exp, "R6", {23'd0, done, cipher_out}, {23'd1, 1'b1, exp});
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(cipher_out == '0 && !done, "R1", {23'd0, done, cipher_out}, 32'd0);
        rst_n = 1'b1;
        // R8: columns before any load are ignored.
        for (int i = 0; i < 4; i++) begin
            col_valid = 1'b1; col_in = key_col(7, i);
            @(negedge clk);
            chk(cipher_out == '0 && !done, "R8", {23'd0, done, cipher_out}, 32'd0);
        end
        col_valid = 1'b0;
        // Exhaustive sweep of the column-select bits.
        for (int p = 0; p < (1 << KC); p++) begin
            logic [N-1:0] pv;
            pv = (N'(p) << R) | N'(R'(p * 29 + 3));
            run_vec(pv, p, 1'b0, "R2");
        end
        // Gapped stream with walking identity bits.
        for (int i = 0; i < 64; i++) begin
            logic [N-1:0] pv;
            pv = (N'(R'(i * 71 + 5)) << R) | N'(R'(1) << (i % R));
            run_vec(pv, i + 300, 1'b1, "R2");
        end
        // R7: restart in the middle of a run.
        start = 1'b1; plain_in = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            col_valid = 1'b1; col_in = key_col(5, k);
            @(negedge clk);
        end
        run_vec(16'h5AC3, 9, 1'b0, "R7");
        run_vec(16'h0000, 10, 1'b1, "R7");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule